// File: doc/BRIEF.md
# Receive Link Health Qualifier

This block sits behind the frame decoder of a serial receive link and decides whether the frames on that link can be trusted enough to act on. It keeps a credit counter in the receive clock domain that is updated once for every received frame. An error-free frame adds a small step. A frame that the decoder has marked as bad removes a larger step. The counter stops at zero and at a ceiling a little above the qualification threshold.

A frame is passed on unchanged only while the counter is above the threshold. Otherwise a fixed safe word takes the place of the frame contents. The same qualification also chooses what the transmit side sends. While the link is qualified, it sends the caller's test pattern. While the link is not qualified, it sends the current credit value as a health report.

A watchdog in a stable reference clock domain watches a heartbeat toggle from the receive domain. If the heartbeat stops for a set number of reference cycles, the receive clock is declared lost. When the receive clock returns, the credit is wiped to zero, so the link has to earn its full credit again. The threshold is a parameter. It is set from the frame rate and the recovery time wanted: about 0.2 s at full link rate and about 0.4 s at half link rate.

Top module: `rx_link_qualifier`

## Requirements
- R1: After reset the credit is 0, `link_ok_o` is 0, `out_vld_o` is 0, `out_data_o` equals SAFE_WORD (default 16'h00F0), `tx_word_o` is 0 and `rxclk_lost_o` is 0.
- R2: When `rx_vld_i` is high at an `rx_clk` edge and `link_ok_o` was already high before that edge, the next edge is followed by `out_vld_o` high and `out_data_o` equal to the received `rx_data_i`. When `rx_vld_i` is low, `out_vld_o` is low and `out_data_o` holds its value.
- R3: When a frame arrives while `link_ok_o` is low, `out_vld_o` still pulses, but `out_data_o` carries SAFE_WORD instead of the frame.
- R4: A frame with `rx_bad_i` low adds GOOD_STEP (default 1) to the credit. The credit never exceeds THRESH+HEADROOM (default 40+4 = 44).
- R5: A frame with `rx_bad_i` high subtracts BAD_STEP (default 8) from the credit, stopping at 0. `rx_bad_i` is ignored when `rx_vld_i` is low.
- R6: `link_ok_o` is a register equal to (credit > THRESH). It updates on the same edge as the credit.
- R7: `rxclk_lost_o` (reference domain) rises once the receive heartbeat has been unchanged for TIMEOUT (default 16) `ref_clk` cycles. It falls within a few reference cycles after `rx_clk` runs again.
- R8: After a loss of the receive clock, the credit is forced to 0 within 4 `rx_clk` cycles of the clock returning. This clear takes priority over any frame arriving in that cycle.
- R9: `tx_word_o` is registered. It equals `tx_pattern_i` when `link_ok_o` was high, and otherwise the credit zero-extended to FRAME_W bits.
- R10: Starting from a credit of 0, exactly THRESH+1 good frames (41 by default) are needed before `link_ok_o` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Stable reference clock for the clock-loss watchdog |
| rx_clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised per domain |
| rx_vld_i | input | 1 | One-cycle strobe: a decoded frame is present |
| rx_bad_i | input | 1 | Decoder flag: the present frame is corrupt |
| rx_data_i | input | FRAME_W | Decoded frame contents |
| tx_pattern_i | input | FRAME_W | Test pattern for the transmit side |
| out_vld_o | output | 1 | Frame strobe toward downstream logic |
| out_data_o | output | FRAME_W | Qualified frame, or SAFE_WORD |
| link_ok_o | output | 1 | Link qualified (credit above threshold) |
| tx_word_o | output | FRAME_W | Test pattern, or the health report |
| rxclk_lost_o | output | 1 | Receive clock absent (ref_clk domain) |

## Verification
A corrupted credit value shows up at the ports in two ways. First, `tx_word_o` carries the credit itself on the edge after it changes, as long as the link is unqualified. Second, `link_ok_o` changes one frame too early or too late, and `out_data_o` then shows SAFE_WORD where a frame was expected, or the other way round. The bench therefore follows the credit frame by frame against its own model and compares all rx-domain outputs one cycle after every edge. The recovery count is pinned down exactly by a directed run of 40 and then 41 good frames. A watchdog that misses the loss, or a clear that fails to cross the domain boundary, shows up within a few receive cycles after the clock returns: either `rxclk_lost_o` stays wrong, or the credit reported on `tx_word_o` is not zero.

// File: rtl/lhq_pkg.sv
package lhq_pkg;
  // Credit update selected for one rx_clk cycle, in priority order
  typedef enum logic [1:0] {
    CR_HOLD  = 2'd0,
    CR_GOOD  = 2'd1,
    CR_BAD   = 2'd2,
    CR_CLEAR = 2'd3
  } credit_op_e;
endpackage

// File: rtl/lhq_rst_sync.sv
module lhq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;
endmodule

// File: rtl/lhq_clk_watch.sv
module lhq_clk_watch #(
  parameter int TIMEOUT = 16
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic hb_async_i,
  output logic lost_o,
  output logic loss_tgl_o
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT);

  logic          hb_s1_q, hb_s2_q, hb_s3_q;
  logic          hb_change;
  logic [TW-1:0] timer_q, timer_d;
  logic          lost_q, lost_d;
  logic          tgl_q, tgl_d;

  assign hb_change = hb_s2_q ^ hb_s3_q;

  always_comb begin
    timer_d = timer_q;
    if (hb_change)
      timer_d = '0;
    else if (timer_q != LIMIT)
      timer_d = timer_q + 1'b1;
    lost_d = !hb_change && (timer_d == LIMIT);
    tgl_d  = tgl_q ^ (lost_d & ~lost_q);
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      hb_s1_q <= 1'b0;
      hb_s2_q <= 1'b0;
      hb_s3_q <= 1'b0;
      timer_q <= '0;
      lost_q  <= 1'b0;
      tgl_q   <= 1'b0;
    end else begin
      hb_s1_q <= hb_async_i;
      hb_s2_q <= hb_s1_q;
      hb_s3_q <= hb_s2_q;
      timer_q <= timer_d;
      lost_q  <= lost_d;
      tgl_q   <= tgl_d;
    end
  end

  assign lost_o     = lost_q;
  assign loss_tgl_o = tgl_q;

  // R7: a seen heartbeat edge always ends a loss indication
  assert_heartbeat_ends_loss_R7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    hb_change |=> !lost_q);
  // R7: a loss is only declared after the timer has run out
  assert_loss_after_timeout_R7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(lost_q) |-> $past(timer_q) >= LIMIT - 1'b1);
endmodule

// File: rtl/lhq_credit.sv
module lhq_credit
  import lhq_pkg::*;
#(
  parameter int THRESH    = 40,
  parameter int HEADROOM  = 4,
  parameter int GOOD_STEP = 1,
  parameter int BAD_STEP  = 8
) (
  input  logic                                    rx_clk,
  input  logic                                    rx_rst_n,
  input  logic                                    frm_vld_i,
  input  logic                                    frm_bad_i,
  input  logic                                    loss_tgl_async_i,
  output logic [$clog2(THRESH+HEADROOM+1)-1:0]    credit_o,
  output logic                                    ok_o,
  output logic                                    hb_o
);
  localparam int CMAX = THRESH + HEADROOM;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int CWX  = CW + 1;
  localparam logic [CWX-1:0] MAX_X  = CWX'(CMAX);
  localparam logic [CWX-1:0] GOOD_X = CWX'(GOOD_STEP);
  localparam logic [CWX-1:0] BAD_X  = CWX'(BAD_STEP);
  localparam logic [CW-1:0]  THR_C  = CW'(THRESH);

  logic          ls1_q, ls2_q, lprev_q;
  logic          clr;
  credit_op_e    op;
  logic [CWX-1:0] sum;
  logic [CW-1:0] cred_q, cred_d;
  logic          ok_q, ok_d;
  logic          hb_q;

  assign clr = ls2_q ^ lprev_q;

  always_comb begin
    if (clr)             op = CR_CLEAR;
    else if (!frm_vld_i) op = CR_HOLD;
    else if (frm_bad_i)  op = CR_BAD;
    else                 op = CR_GOOD;

    sum    = {1'b0, cred_q} + GOOD_X;
    cred_d = cred_q;
    case (op)
      CR_CLEAR: cred_d = '0;
      CR_GOOD:  cred_d = (sum > MAX_X) ? MAX_X[CW-1:0] : sum[CW-1:0];
      CR_BAD:   cred_d = ({1'b0, cred_q} >= BAD_X) ? cred_q - BAD_X[CW-1:0] : '0;
      default:  cred_d = cred_q;
    endcase
    ok_d = cred_d > THR_C;
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      ls1_q   <= 1'b0;
      ls2_q   <= 1'b0;
      lprev_q <= 1'b0;
      cred_q  <= '0;
      ok_q    <= 1'b0;
      hb_q    <= 1'b0;
    end else begin
      ls1_q   <= loss_tgl_async_i;
      ls2_q   <= ls1_q;
      lprev_q <= ls2_q;
      cred_q  <= cred_d;
      ok_q    <= ok_d;
      hb_q    <= ~hb_q;
    end
  end

  assign credit_o = cred_q;
  assign ok_o     = ok_q;
  assign hb_o     = hb_q;

  // R4: the credit never leaves its range
  assert_credit_bounded_R4: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    cred_q <= MAX_X[CW-1:0]);
  // R5: a bad frame never raises the credit
  assert_bad_not_rising_R5: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (frm_vld_i && frm_bad_i) |=> cred_q <= $past(cred_q));
  // R8: a crossed clock-loss event wipes the credit
  assert_loss_clears_R8: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    clr |=> (cred_q == '0 && !ok_q));
  // R6: qualification tracks the credit
  assert_ok_matches_credit_R6: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    ok_q == (cred_q > THR_C));
endmodule

// File: rtl/lhq_frame_gate.sv
module lhq_frame_gate #(
  parameter int                FRAME_W   = 16,
  parameter int                CW        = 6,
  parameter logic [FRAME_W-1:0] SAFE_WORD = 16'h00F0
) (
  input  logic               rx_clk,
  input  logic               rx_rst_n,
  input  logic               vld_i,
  input  logic [FRAME_W-1:0] data_i,
  input  logic               ok_i,
  input  logic [CW-1:0]      credit_i,
  input  logic [FRAME_W-1:0] pattern_i,
  output logic               out_vld_o,
  output logic [FRAME_W-1:0] out_data_o,
  output logic [FRAME_W-1:0] tx_word_o
);
  logic               vld_q;
  logic [FRAME_W-1:0] data_q, data_d;
  logic [FRAME_W-1:0] tx_q, tx_d;

  always_comb begin
    data_d = data_q;
    if (vld_i)
      data_d = ok_i ? data_i : SAFE_WORD;
    tx_d = ok_i ? pattern_i : FRAME_W'(credit_i);
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      vld_q  <= 1'b0;
      data_q <= SAFE_WORD;
      tx_q   <= '0;
    end else begin
      vld_q  <= vld_i;
      data_q <= data_d;
      tx_q   <= tx_d;
    end
  end

  assign out_vld_o  = vld_q;
  assign out_data_o = data_q;
  assign tx_word_o  = tx_q;

  // R2: a qualified frame is forwarded intact
  assert_forward_when_ok_R2: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (vld_i && ok_i) |=> (out_vld_o && out_data_o == $past(data_i)));
  // R3: an unqualified frame is replaced
  assert_safe_when_bad_link_R3: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (vld_i && !ok_i) |=> (out_vld_o && out_data_o == SAFE_WORD));
endmodule

// File: rtl/rx_link_qualifier.sv
module rx_link_qualifier #(
  parameter int                 FRAME_W   = 16,
  parameter int                 THRESH    = 40,
  parameter int                 HEADROOM  = 4,
  parameter int                 GOOD_STEP = 1,
  parameter int                 BAD_STEP  = 8,
  parameter int                 TIMEOUT   = 16,
  parameter logic [FRAME_W-1:0] SAFE_WORD = 16'h00F0
) (
  input  logic               ref_clk,
  input  logic               rx_clk,
  input  logic               rst_n,
  input  logic               rx_vld_i,
  input  logic               rx_bad_i,
  input  logic [FRAME_W-1:0] rx_data_i,
  input  logic [FRAME_W-1:0] tx_pattern_i,
  output logic               out_vld_o,
  output logic [FRAME_W-1:0] out_data_o,
  output logic               link_ok_o,
  output logic [FRAME_W-1:0] tx_word_o,
  output logic               rxclk_lost_o
);
  localparam int CW = $clog2(THRESH + HEADROOM + 1);

  logic          ref_rst_n, rx_rst_n;
  logic          hb, loss_tgl, ok;
  logic [CW-1:0] credit;

  lhq_rst_sync u_ref_rst (.clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n));
  lhq_rst_sync u_rx_rst  (.clk(rx_clk),  .arst_n(rst_n), .srst_n(rx_rst_n));

  lhq_clk_watch #(.TIMEOUT(TIMEOUT)) u_watch (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .hb_async_i(hb),
    .lost_o(rxclk_lost_o), .loss_tgl_o(loss_tgl)
  );

  lhq_credit #(
    .THRESH(THRESH), .HEADROOM(HEADROOM),
    .GOOD_STEP(GOOD_STEP), .BAD_STEP(BAD_STEP)
  ) u_credit (
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .frm_vld_i(rx_vld_i),
    .frm_bad_i(rx_bad_i), .loss_tgl_async_i(loss_tgl),
    .credit_o(credit), .ok_o(ok), .hb_o(hb)
  );

  lhq_frame_gate #(.FRAME_W(FRAME_W), .CW(CW), .SAFE_WORD(SAFE_WORD)) u_gate (
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .vld_i(rx_vld_i), .data_i(rx_data_i),
    .ok_i(ok), .credit_i(credit), .pattern_i(tx_pattern_i),
    .out_vld_o(out_vld_o), .out_data_o(out_data_o), .tx_word_o(tx_word_o)
  );

  assign link_ok_o = ok;
endmodule

// File: tb/rx_link_qualifier_tb.sv
`timescale 1ns/1ps
module rx_link_qualifier_tb_top;
  localparam int FW = 16;
  localparam int THR = 40;
  localparam int CMAX = 44;
  localparam int BSTEP = 8;
  localparam logic [FW-1:0] SAFE = 16'h00F0;

  logic ref_clk = 1'b0;
  logic rx_clk = 1'b0;
  logic rx_run = 1'b1;
  logic rst_n = 1'b0;
  logic rx_vld = 1'b0, rx_bad = 1'b0;
  logic [FW-1:0] rx_data = '0, tx_pat = '0;
  logic out_vld, link_ok, lost;
  logic [FW-1:0] out_data, tx_word;

  int n_cmp = 0, n_bad = 0;
  int m_cred = 0;
  bit m_ok = 0;
  logic [FW-1:0] m_out = SAFE;
  bit done = 0;

  always #2.5 ref_clk = ~ref_clk;
  always #3.5 if (rx_run) rx_clk = ~rx_clk;

  rx_link_qualifier dut_i (
    .ref_clk(ref_clk), .rx_clk(rx_clk), .rst_n(rst_n),
    .rx_vld_i(rx_vld), .rx_bad_i(rx_bad), .rx_data_i(rx_data),
    .tx_pattern_i(tx_pat), .out_vld_o(out_vld), .out_data_o(out_data),
    .link_ok_o(link_ok), .tx_word_o(tx_word), .rxclk_lost_o(lost)
  );

  function automatic int next_credit(int c, bit v, bit b);
    if (!v) return c;
    if (b) return (c >= BSTEP) ? c - BSTEP : 0;
    return (c + 1 > CMAX) ? CMAX : c + 1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one rx cycle: drive at negedge, compare after the following edge
  task automatic step(bit v, bit b, logic [FW-1:0] d, logic [FW-1:0] p, bit chk);
    logic [FW-1:0] e_tx;
    rx_vld = v; rx_bad = b; rx_data = d; tx_pat = p;
    e_tx = m_ok ? p : FW'(m_cred);
    if (v) m_out = m_ok ? d : SAFE;
    m_cred = next_credit(m_cred, v, b);
    m_ok = (m_cred > THR);
    @(posedge rx_clk);
    @(negedge rx_clk);
    if (chk) begin
      check("R2 out_vld", out_vld, v);
      check(m_ok ? "R2 out_data" : "R3 out_data", out_data, m_out);
      check("R6 link_ok", link_ok, m_ok);
      check("R9 tx_word", tx_word, e_tx);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h1234);
    #23 rst_n = 1'b1;
    @(negedge rx_clk);
    // R1: reset state
    check("R1 out_vld", out_vld, 0);
    check("R1 out_data", out_data, SAFE);
    check("R1 link_ok", link_ok, 0);
    check("R1 tx_word", tx_word, 0);
    check("R1 lost", lost, 0);
    for (int i = 0; i < 10; i++) step(0, 0, '0, 16'hA5A5, 1);

    // R10: 40 good frames keep the link down, the 41st qualifies it
    for (int i = 0; i < 40; i++) step(1, 0, FW'(i), 16'h1111, 1);
    check("R10 after 40", link_ok, 0);
    step(1, 0, 16'hBEEF, 16'h1111, 1);
    check("R10 after 41", link_ok, 1);
    // R2: forwarded data; R4: saturation at ceiling
    for (int i = 0; i < 8; i++) step(1, 0, 16'hC000 + FW'(i), 16'h2222, 1);
    // R5: bad frames drain to zero and saturate; bad without strobe ignored
    for (int i = 0; i < 7; i++) step(1, 1, 16'hD000 + FW'(i), 16'h3333, 1);
    step(0, 1, 16'hFFFF, 16'h3333, 1);
    check("R5 floor via tx", tx_word, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      bit v, b;
      v = ($urandom_range(0, 9) < 8);
      b = ($urandom_range(0, 19) == 0);
      step(v, b, FW'($urandom), FW'($urandom), 1);
    end

    // build credit before the clock loss
    for (int i = 0; i < 50; i++) step(1, 0, FW'(i), 16'h4444, 1);
    check("R8 pre-loss ok", link_ok, 1);
    rx_run = 1'b0;
    repeat (40) @(posedge ref_clk);
    #1 check("R7 lost high", lost, 1);
    rx_run = 1'b1;
    for (int i = 0; i < 6; i++) step(0, 0, '0, 16'h5555, 0);
    m_cred = 0; m_ok = 0;
    check("R7 lost cleared", lost, 0);
    check("R8 link_ok after loss", link_ok, 0);
    step(0, 0, '0, 16'h5555, 1);
    check("R8 credit zero", tx_word, 0);
    for (int i = 0; i < 41; i++) step(1, 0, FW'(i), 16'h6666, 1);
    check("R10 recovered", link_ok, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule